// File: doc/BRIEF.md
# Packed Subtest Sequencer

The sequencer walks a short test program made of 16-bit subtest descriptors and hands them, one at a time, to an external operation engine. The descriptors are held in eight 64-bit program registers, four descriptors to a register, which gives room for 32 subtests. Software loads the program registers, issues a start, and then polls a three-bit status: busy, done and fail.

There is no length register. The program ends at the first descriptor whose end flag is set. If no descriptor carries the flag, the program runs to the last slot. Each descriptor is presented on an issue port and held there until the engine acknowledges it. The engine can flag an error with that acknowledge. At the end, a clean run reports done and a run that saw any error reports fail; the two never appear together. A stop command abandons the run without reporting either outcome. A status-clear command wipes done and fail, but only when the sequencer is idle.

Top module: `sbs_sequencer`

## Requirements
- R1: Program register k (selected by `prog_sel`) holds slots 4k to 4k+3. Slot 4k sits in bits 63:48 and slot 4k+3 in bits 15:0. While busy, `issue_desc` carries the 16-bit contents of the slot numbered by `issue_slot`.
- R2: Bit 15 of a descriptor is its end flag. The cycle after the acknowledge of a flagged slot, busy is low and exactly one of done and fail is high.
- R3: A start pulse while idle (and without stop) raises busy on the next cycle, clears done and fail, and presents slot 0. A start pulse while busy has no effect.
- R4: While `issue_valid` is high and `issue_ack` is low, the slot number and descriptor hold steady. An acknowledge on a slot that is neither flagged nor the last advances `issue_slot` by one on the next cycle.
- R5: If no descriptor carries the end flag, the run ends after slot 31 is acknowledged and reports done.
- R6: A run whose acknowledges all had `issue_err` low ends with done=1 and fail=0. If any acknowledge had `issue_err` high, the run ends with done=0 and fail=1. Done and fail are both low while busy.
- R7: Stop while busy ends the run on the next cycle with busy, done and fail all low. Stop takes priority over an acknowledge in the same cycle, including the final one. Stop while idle changes nothing.
- R8: `status_clr` while idle clears done and fail on the next cycle. It is ignored while busy, including in the cycle of the final acknowledge.
- R9: Writes to the program registers while busy are ignored.
- R10: After reset, busy, issue_valid, done and fail are low and all program registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Program register write strobe |
| prog_sel | input | 3 | Program register number |
| prog_wdata | input | 64 | Program register write data |
| start | input | 1 | Start command pulse |
| stop | input | 1 | Stop command pulse |
| status_clr | input | 1 | Clear done and fail |
| issue_valid | output | 1 | A descriptor is offered to the engine |
| issue_slot | output | 5 | Number of the offered slot |
| issue_desc | output | 16 | Offered descriptor |
| issue_ack | input | 1 | Engine has finished the offered subtest |
| issue_err | input | 1 | Error flag, sampled with issue_ack |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished clean |
| fail | output | 1 | Last run saw an error |

## Verification
Two pairs of events can land on the same edge: the final acknowledge together with a stop, and the final acknowledge together with a status clear. The bench drives each pair in one cycle. With stop, the run must end with neither done nor fail set, so stop wins. With status clear, done must survive, because the clear arrived while the run was still busy. A start pulse and a program write issued in the middle of a run are judged by the slot number that follows and by a second run of the unchanged program.

// File: rtl/sbs_pkg.sv
// Package sbs_pkg
// Shared types for the packed subtest sequencer.
// Assumes: nothing beyond the 1800-2017 language.
package sbs_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/sbs_prog_store.sv
// Module sbs_prog_store
// Holds the program registers and selects one packed slot for the issue port.
// Assumes: NUM_REGS is a power of two; slot 0 of each register is in its top bits.
module sbs_prog_store #(
    parameter int NUM_REGS      = 8,
    parameter int SLOTS_PER_REG = 4,
    parameter int SLOT_W        = 16
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0]                 wr_idx,
    input  logic [SLOTS_PER_REG*SLOT_W-1:0]             wr_data,
    input  logic                                        lock,
    input  logic [$clog2(NUM_REGS*SLOTS_PER_REG)-1:0]   rd_slot,
    output logic [SLOT_W-1:0]                           rd_desc
);
    localparam int REG_W     = SLOTS_PER_REG * SLOT_W;
    localparam int NUM_SLOTS = NUM_REGS * SLOTS_PER_REG;

    logic [REG_W-1:0]  prog_q    [NUM_REGS];
    logic [SLOT_W-1:0] slot_flat [NUM_SLOTS];

    // Register write: accepted only while no run holds the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                prog_q[r] <= '0;
            end
        end else if (wr_en && !lock) begin
            prog_q[wr_idx] <= wr_data;
        end
    end

    // Unpack every register into a flat slot list, slot 0 taken from the top bits.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar j = 0; j < SLOTS_PER_REG; j++) begin : g_slot
            assign slot_flat[r*SLOTS_PER_REG + j] = prog_q[r][REG_W-1-j*SLOT_W -: SLOT_W];
        end
    end

    // Slot select for the issue port.
    always_comb begin
        rd_desc = slot_flat[rd_slot];
    end
endmodule

// File: rtl/sbs_ctrl.sv
// Module sbs_ctrl
// Run control: launches, steps on each acknowledge, ends on the flagged or last slot.
// Assumes: stop outranks start and acknowledge; errors are sampled only with an acknowledge.
module sbs_ctrl
    import sbs_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 16,
    parameter int DONE_BIT  = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          stop,
    input  logic                          ack,
    input  logic                          err,
    input  logic [SLOT_W-1:0]             desc,
    output logic                          running,
    output logic [$clog2(NUM_SLOTS)-1:0]  slot,
    output logic                          launch,
    output logic                          finish,
    output logic                          finish_fail
);
    localparam int SIDX_W = $clog2(NUM_SLOTS);
    localparam logic [SIDX_W-1:0] LAST_SLOT = SIDX_W'(NUM_SLOTS - 1);

    seq_state_e        state_q;
    logic [SIDX_W-1:0] slot_q;
    logic              err_q;
    logic              accept;
    logic              at_end;

    // Decode of this cycle's events.
    always_comb begin
        running     = (state_q == SEQ_RUN);
        accept      = running && ack && !stop;
        at_end      = desc[DONE_BIT] || (slot_q == LAST_SLOT);
        launch      = !running && start && !stop;
        finish      = accept && at_end;
        finish_fail = err_q || err;
        slot        = slot_q;
    end

    // State, slot pointer and sticky error of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            slot_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (launch) begin
                        state_q <= SEQ_RUN;
                        slot_q  <= '0;
                        err_q   <= 1'b0;
                    end
                end
                SEQ_RUN: begin
                    if (stop) begin
                        state_q <= SEQ_IDLE;
                    end else if (accept) begin
                        err_q <= err_q || err;
                        if (at_end) begin
                            state_q <= SEQ_IDLE;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sbs_status.sv
// Module sbs_status
// Done and fail flags of the last finished run.
// Assumes: launch and finish never occur in the same cycle.
module sbs_status (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic finish,
    input  logic finish_fail,
    input  logic clear,
    input  logic running,
    output logic done,
    output logic fail
);
    // Outcome flags: cleared on launch, set on finish, clearable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            fail <= 1'b0;
        end else if (launch) begin
            done <= 1'b0;
            fail <= 1'b0;
        end else if (finish) begin
            done <= !finish_fail;
            fail <= finish_fail;
        end else if (clear && !running) begin
            done <= 1'b0;
            fail <= 1'b0;
        end
    end
endmodule

// File: rtl/sbs_sequencer.sv
// Module sbs_sequencer
// Top of the packed subtest sequencer: program store, run control and status.
// Assumes: one descriptor in flight; the engine acknowledges each one exactly once.
module sbs_sequencer #(
    parameter int NUM_REGS      = 8,
    parameter int SLOTS_PER_REG = 4,
    parameter int SLOT_W        = 16,
    parameter int DONE_BIT      = 15
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        prog_we,
    input  logic [$clog2(NUM_REGS)-1:0]                 prog_sel,
    input  logic [SLOTS_PER_REG*SLOT_W-1:0]             prog_wdata,
    input  logic                                        start,
    input  logic                                        stop,
    input  logic                                        status_clr,
    output logic                                        issue_valid,
    output logic [$clog2(NUM_REGS*SLOTS_PER_REG)-1:0]   issue_slot,
    output logic [SLOT_W-1:0]                           issue_desc,
    input  logic                                        issue_ack,
    input  logic                                        issue_err,
    output logic                                        busy,
    output logic                                        done,
    output logic                                        fail
);
    localparam int NUM_SLOTS = NUM_REGS * SLOTS_PER_REG;
    localparam int SIDX_W    = $clog2(NUM_SLOTS);

    logic              running;
    logic              launch;
    logic              finish;
    logic              finish_fail;
    logic [SIDX_W-1:0] slot;

    sbs_prog_store #(
        .NUM_REGS      (NUM_REGS),
        .SLOTS_PER_REG (SLOTS_PER_REG),
        .SLOT_W        (SLOT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prog_we),
        .wr_idx  (prog_sel),
        .wr_data (prog_wdata),
        .lock    (running),
        .rd_slot (slot),
        .rd_desc (issue_desc)
    );

    sbs_ctrl #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W),
        .DONE_BIT  (DONE_BIT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .stop        (stop),
        .ack         (issue_ack),
        .err         (issue_err),
        .desc        (issue_desc),
        .running     (running),
        .slot        (slot),
        .launch      (launch),
        .finish      (finish),
        .finish_fail (finish_fail)
    );

    sbs_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .finish      (finish),
        .finish_fail (finish_fail),
        .clear       (status_clr),
        .running     (running),
        .done        (done),
        .fail        (fail)
    );

    // Port drive: the offer is open exactly while a run is in progress.
    always_comb begin
        issue_valid = running;
        issue_slot  = slot;
        busy        = running;
    end
endmodule

// File: rtl/sbs_sequencer_chk.sv
// Module sbs_sequencer_chk
// Port-level properties of the sequencer, bound into every instance.
// Assumes: the same parameters as the instance it is bound to.
module sbs_sequencer_chk #(
    parameter int NUM_REGS      = 8,
    parameter int SLOTS_PER_REG = 4,
    parameter int SLOT_W        = 16,
    parameter int DONE_BIT      = 15
) (
    input logic                                        clk,
    input logic                                        rst_n,
    input logic                                        start,
    input logic                                        stop,
    input logic                                        status_clr,
    input logic                                        issue_valid,
    input logic [$clog2(NUM_REGS*SLOTS_PER_REG)-1:0]   issue_slot,
    input logic [SLOT_W-1:0]                           issue_desc,
    input logic                                        issue_ack,
    input logic                                        issue_err,
    input logic                                        busy,
    input logic                                        done,
    input logic                                        fail
);
    localparam int SIDX_W = $clog2(NUM_REGS * SLOTS_PER_REG);
    localparam logic [SIDX_W-1:0] LAST_SLOT = SIDX_W'(NUM_REGS * SLOTS_PER_REG - 1);

    a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop && !busy) |=> (busy && issue_slot == '0 && !done && !fail));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_ack && !stop) |=>
        (issue_valid && $stable(issue_slot) && $stable(issue_desc)));

    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ack && !stop && !issue_desc[DONE_BIT] && issue_slot != LAST_SLOT) |=>
        (issue_valid && issue_slot == $past(issue_slot) + 1'b1));

    a_r2_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ack && !stop && issue_desc[DONE_BIT]) |=>
        (!busy && (done != fail)));

    a_r5_last_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ack && !stop && issue_slot == LAST_SLOT) |=> !busy);

    a_r6_error_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ack && issue_err && !stop &&
         (issue_desc[DONE_BIT] || issue_slot == LAST_SLOT)) |=> (fail && !done));

    a_r6_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done && !fail));

    a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop) |=> (!busy && !done && !fail));

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && !busy) |=> (!done && !fail));
endmodule

bind sbs_sequencer sbs_sequencer_chk #(
    .NUM_REGS      (NUM_REGS),
    .SLOTS_PER_REG (SLOTS_PER_REG),
    .SLOT_W        (SLOT_W),
    .DONE_BIT      (DONE_BIT)
) u_chk (.*);

// File: tb/sbs_sequencer_bench.sv
// Module sbs_sequencer_bench
// Sweeps every program length, with and without errors, plus the same-cycle collisions.
// Assumes: default parameters (8 registers, 4 slots each, 16-bit slots, flag in bit 15).
module sbs_sequencer_bench;
    localparam int NS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [2:0]  prog_sel = '0;
    logic [63:0] prog_wdata = '0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        status_clr = 1'b0;
    logic        issue_valid;
    logic [4:0]  issue_slot;
    logic [15:0] issue_desc;
    logic        issue_ack = 1'b0;
    logic        issue_err = 1'b0;
    logic        busy;
    logic        done;
    logic        fail;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [15:0] exp_mem [NS];

    always #4 clk = ~clk;

    sbs_sequencer u_sbs_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_we     (prog_we),
        .prog_sel    (prog_sel),
        .prog_wdata  (prog_wdata),
        .start       (start),
        .stop        (stop),
        .status_clr  (status_clr),
        .issue_valid (issue_valid),
        .issue_slot  (issue_slot),
        .issue_desc  (issue_desc),
        .issue_ack   (issue_ack),
        .issue_err   (issue_err),
        .busy        (busy),
        .done        (done),
        .fail        (fail)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL R4 watchdog expired: actual=%0d cycles expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] gen_desc(input int rid, input int s);
        return 16'((s * 177 + rid * 965 + 7) & 32'h7fff);
    endfunction

    // R1: slot 4k at bits 63:48 of register k; end flag in bit 15 of the last slot when flag=1.
    task automatic load_prog(input int rid, input int len, input bit flag);
        for (int s = 0; s < NS; s++) begin
            exp_mem[s] = gen_desc(rid, s);
            if (flag && s == len - 1) exp_mem[s][15] = 1'b1;
        end
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            prog_we    = 1'b1;
            prog_sel   = 3'(r);
            prog_wdata = {exp_mem[4*r], exp_mem[4*r+1], exp_mem[4*r+2], exp_mem[4*r+3]};
        end
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic run_prog(input int rid, input int len, input int err_slot, input int stop_slot,
                            input bit clr_final, input bit poke);
        bit expect_fail;
        expect_fail = (err_slot >= 0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R3 busy after start", 64'(busy), 64'd1);
        chk(done === 1'b0 && fail === 1'b0, "R3 status cleared at start", 64'({done, fail}), 64'd0);
        for (int s = 0; s < len; s++) begin
            int d;
            chk(issue_valid === 1'b1 && issue_slot === 5'(s), "R4 slot order", 64'(issue_slot), 64'(s));
            chk(issue_desc === exp_mem[s], "R1 descriptor unpack", 64'(issue_desc), 64'(exp_mem[s]));
            if (poke && s == 1) begin
                start      = 1'b1;
                prog_we    = 1'b1;
                prog_sel   = 3'd0;
                prog_wdata = '1;
                @(negedge clk);
                start   = 1'b0;
                prog_we = 1'b0;
                chk(issue_slot === 5'd1 && busy === 1'b1, "R3 start ignored while busy",
                    64'(issue_slot), 64'd1);
            end
            d = (s + rid) % 3;
            for (int w = 0; w < d; w++) begin
                @(negedge clk);
                chk(issue_valid === 1'b1 && issue_slot === 5'(s) && issue_desc === exp_mem[s],
                    "R4 hold without ack", 64'(issue_slot), 64'(s));
            end
            issue_ack = 1'b1;
            issue_err = (s == err_slot);
            if (s == stop_slot) stop = 1'b1;
            if (clr_final && s == len - 1) status_clr = 1'b1;
            @(negedge clk);
            issue_ack  = 1'b0;
            issue_err  = 1'b0;
            stop       = 1'b0;
            status_clr = 1'b0;
            if (s == stop_slot) begin
                chk(busy === 1'b0 && done === 1'b0 && fail === 1'b0, "R7 stop aborts with no outcome",
                    64'({busy, done, fail}), 64'd0);
                return;
            end
        end
        chk(busy === 1'b0, "R2 run ends at flagged or last slot", 64'(busy), 64'd0);
        chk(done === !expect_fail && fail === expect_fail, "R6 outcome flags",
            64'({done, fail}), expect_fail ? 64'd1 : 64'd2);
        if (clr_final)
            chk(done === 1'b1, "R8 clear ignored on final ack", 64'(done), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && issue_valid === 1'b0 && done === 1'b0 && fail === 1'b0,
            "R10 reset state", 64'({busy, issue_valid, done, fail}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(issue_desc === 16'd0, "R10 program cleared by reset", 64'(issue_desc), 64'd0);

        // R2 and R6: every program length, errors on every third length.
        for (int len = 1; len <= NS; len++) begin
            load_prog(len, len, 1'b1);
            run_prog(len, len, (len % 3 == 0) ? len / 2 : -1, -1, 1'b0, 1'b0);
        end

        // R5: no end flag anywhere, run to slot 31 and report done.
        load_prog(40, NS, 1'b0);
        run_prog(40, NS, -1, -1, 1'b0, 1'b0);
        chk(done === 1'b1, "R5 done after slot 31", 64'(done), 64'd1);

        // R6: error on the final slot only.
        load_prog(45, 3, 1'b1);
        run_prog(45, 3, 2, -1, 1'b0, 1'b0);

        // R7: stop in mid-run, then stop while idle.
        load_prog(41, 10, 1'b1);
        run_prog(41, 10, -1, 4, 1'b0, 1'b0);
        // R7: stop together with the final acknowledge.
        load_prog(42, 5, 1'b1);
        run_prog(42, 5, -1, 4, 1'b0, 1'b0);

        // R8: clear with the final acknowledge, then clear while idle.
        load_prog(43, 6, 1'b1);
        run_prog(43, 6, -1, -1, 1'b1, 1'b0);
        @(negedge clk);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        chk(done === 1'b0 && fail === 1'b0, "R8 clear while idle", 64'({done, fail}), 64'd0);

        // R7: stop while idle keeps the outcome.
        run_prog(43, 6, -1, -1, 1'b0, 1'b0);
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, "R7 stop while idle ignored", 64'({busy, done}), 64'd1);

        // R9: start and a program write in mid-run; the rerun must see the old program.
        load_prog(44, 8, 1'b1);
        run_prog(44, 8, -1, -1, 1'b0, 1'b1);
        run_prog(44, 8, -1, -1, 1'b0, 1'b0);
        chk(done === 1'b1, "R9 write during run ignored", 64'(done), 64'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule